// File: doc/BRIEF.md
# Channel Buffer Submission Controller

This block handles the device-to-host direction of a single streaming data channel. Words arrive on a valid/ready input and are placed, in arrival order, into a ring of equally sized host buffers. The buffers are written through a plain address/data write port. The address is the buffer index joined to the word offset inside that buffer. When a buffer fills, or when the host asks for a flush while the buffer holds some words, the block hands the buffer to the host. It does this by emitting a release message that names the buffer and the number of valid words in it. The message is tagged with this block's data channel number and is carried on the dedicated message channel, channel 0. A handed-over buffer stays locked until the host writes its index back through the release strobe. While the current buffer is locked, the input is stalled.

To let the host wake a waiting poll without a full buffer, the block also emits a one-shot "channel has data" message. It sends this message when the first word lands in an empty buffer. Every message raises a level interrupt request, which stays up until the host clears it. The word width (8, 16 or 32 bits), the buffer size, the buffer count (both powers of two), the channel number (1 or higher) and whether the data-present message is sent are all parameters.

Top module: `chan_submit_ctrl`

## Requirements
- R1: After synchronous reset `inReady` is 1, `memWrEn`, `msgValid` and `irq` are 0, and every buffer is free. The first accepted word goes to buffer 0, offset 0.
- R2: A word is accepted when `inValid` and `inReady` are both 1. In the next cycle `memWrEn` is 1, `memWrData` holds the word, and `memWrAddr` is {buffer index, offset}, with the index in the upper bits. The offset starts at 0 in each buffer and rises by one per accepted word.
- R3: When an accepted word fills the current buffer, a release message appears in the same cycle as that word's write. It has `msgOpcode` = 1, `msgBufIdx` equal to the buffer index, and `msgCount` equal to the buffer size in words.
- R4: After any submission the next word goes to offset 0 of the next buffer index, which wraps from the last index to 0.
- R5: A one-cycle `flushStrobe` submits the current buffer with `msgCount` equal to the words held, including a word accepted in the same cycle. A flush on an empty buffer produces no message. A flush in the cycle a buffer fills produces one message only, with the full count.
- R6: A submitted buffer is never written again until a `relStrobe` carries its index. `inReady` is 0 while the current buffer is locked, and releasing a different index leaves `inReady` at 0.
- R7: When the data-present message is enabled, the first word accepted into an empty buffer yields one message with `msgOpcode` = 2, `msgBufIdx` equal to the current index, and `msgCount` = 0. It is re-armed after each submission. When that first word is itself submitted in the same cycle, only the release message is sent. When the message is disabled by parameter, opcode 2 never appears.
- R8: `irq` goes to 1 in the same cycle as any message and stays 1 until `irqClear` is pulsed. A clear in the cycle that produces a new message leaves `irq` at 1.
- R9: `msgChan` always carries the configured data channel number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inData | input | WORD_W | Incoming data word |
| inValid | input | 1 | Incoming word is present |
| inReady | output | 1 | Current buffer is free to accept words |
| memWrEn | output | 1 | Host memory write strobe |
| memWrAddr | output | IDX_W+OFF_W | Buffer index (upper bits) and word offset |
| memWrData | output | WORD_W | Word to store |
| relStrobe | input | 1 | Host returns a buffer for reuse |
| relIndex | input | IDX_W | Index of the returned buffer |
| flushStrobe | input | 1 | Host asks to submit a partial buffer |
| irqClear | input | 1 | Host acknowledges the interrupt |
| msgValid | output | 1 | A message is presented this cycle |
| msgChan | output | CHAN_W | Data channel the message concerns |
| msgOpcode | output | 2 | 1 = buffer release, 2 = channel has data |
| msgBufIdx | output | IDX_W | Buffer the message refers to |
| msgCount | output | CNT_W | Valid words in a released buffer, 0 otherwise |
| irq | output | 1 | Interrupt request level |

## Verification
The fill path is driven with back-to-back words that complete a buffer. This separates a full-count release from the data-present message that comes before it. Partial flushes are tried after idle gaps, on an empty buffer, on the cycle a buffer fills and on the very first word of a buffer. These show whether the count includes the word of the same cycle, and whether the message is dropped, merged or suppressed. Running all buffers into the locked state and returning them out of order checks that a write never lands in a buffer the host still owns. A second copy with the data-present message disabled receives the same traffic and must report the same releases and nothing else.

// File: rtl/csc_pkg.sv
package csc_pkg;

  typedef enum logic [1:0] {
    MSG_NONE     = 2'd0,
    MSG_RELEASE  = 2'd1,
    MSG_NONEMPTY = 2'd2
  } msg_op_e;

  // strobes from the control to the datapath, one cycle wide
  typedef struct packed {
    logic wrAccept;       // word accepted this cycle
    logic submit;         // current buffer is handed to the host
    logic notifyNonempty; // first word landed in an empty buffer
  } ctrl_strobe_t;

endpackage

// File: rtl/csc_ctrl.sv
module csc_ctrl
  import csc_pkg::*;
#(
  parameter int BUF_WORDS   = 16,
  parameter int BUF_COUNT   = 4,
  parameter bit NONEMPTY_EN = 1'b1,
  localparam int IDX_W = (BUF_COUNT > 1) ? $clog2(BUF_COUNT) : 1,
  localparam int CNT_W = $clog2(BUF_WORDS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic             flushStrobe,
  input  logic             relStrobe,
  input  logic [IDX_W-1:0] relIndex,
  output logic             inReady,
  output ctrl_strobe_t     strobes,
  output logic [IDX_W-1:0] curIdx,
  output logic [CNT_W-1:0] fillCnt,
  output logic [CNT_W-1:0] subCount
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BUF_COUNT - 1);
  localparam logic [CNT_W-1:0] FULL_M1  = CNT_W'(BUF_WORDS - 1);

  logic [BUF_COUNT-1:0] freeMask;
  logic                 accept;
  logic                 submit;
  logic [CNT_W-1:0]     fillNext;
  logic [IDX_W-1:0]     nextIdx;

  assign inReady  = freeMask[curIdx];
  assign accept   = inValid & inReady;
  assign fillNext = fillCnt + CNT_W'(accept);
  assign submit   = (accept && (fillCnt == FULL_M1)) ||
                    (flushStrobe && (fillNext != '0));
  assign subCount = fillNext;
  assign nextIdx  = (curIdx == LAST_IDX) ? '0 : curIdx + 1'b1;

  always_comb begin
    strobes.wrAccept       = accept;
    strobes.submit         = submit;
    strobes.notifyNonempty = NONEMPTY_EN && accept && (fillCnt == '0) && !submit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      curIdx  <= '0;
      fillCnt <= '0;
    end else if (submit) begin
      curIdx  <= nextIdx;
      fillCnt <= '0;
    end else begin
      fillCnt <= fillNext;
    end
  end

  // one ownership flag per buffer: locking by submission wins over a release
  for (genvar g = 0; g < BUF_COUNT; g++) begin : g_slot
    logic slotFree;
    always_ff @(posedge clk) begin
      if (rst)
        slotFree <= 1'b1;
      else if (submit && (curIdx == IDX_W'(g)))
        slotFree <= 1'b0;
      else if (relStrobe && (relIndex == IDX_W'(g)))
        slotFree <= 1'b1;
    end
    assign freeMask[g] = slotFree;
  end

  // R2: the write offset never runs past the buffer
  assert_fill_bound_R2: assert property (@(posedge clk) disable iff (rst)
    fillCnt < CNT_W'(BUF_WORDS));

  // R4: a submission restarts the offset
  assert_offset_restart_R4: assert property (@(posedge clk) disable iff (rst)
    submit |=> (fillCnt == '0));

  // R6: a buffer just handed over is locked on the next cycle
  assert_submitted_held_R6: assert property (@(posedge clk) disable iff (rst)
    submit |=> !freeMask[$past(curIdx)]);

  // R6: input readiness only comes back through a host release
  assert_ready_source_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(inReady) |-> $past(relStrobe));

endmodule

// File: rtl/csc_datapath.sv
module csc_datapath
  import csc_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int BUF_WORDS = 16,
  parameter int BUF_COUNT = 4,
  parameter int CHAN_ID   = 1,
  parameter int CHAN_W    = 8,
  localparam int IDX_W  = (BUF_COUNT > 1) ? $clog2(BUF_COUNT) : 1,
  localparam int OFF_W  = (BUF_WORDS > 1) ? $clog2(BUF_WORDS) : 1,
  localparam int CNT_W  = $clog2(BUF_WORDS + 1),
  localparam int ADDR_W = IDX_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrl_strobe_t      strobes,
  input  logic [IDX_W-1:0]  curIdx,
  input  logic [CNT_W-1:0]  fillCnt,
  input  logic [CNT_W-1:0]  subCount,
  input  logic [WORD_W-1:0] inData,
  input  logic              irqClear,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [WORD_W-1:0] memWrData,
  output logic              msgValid,
  output logic [CHAN_W-1:0] msgChan,
  output logic [1:0]        msgOpcode,
  output logic [IDX_W-1:0]  msgBufIdx,
  output logic [CNT_W-1:0]  msgCount,
  output logic              irq
);

  msg_op_e opNext;
  logic    anyMsg;

  assign anyMsg  = strobes.submit | strobes.notifyNonempty;
  assign msgChan = CHAN_W'(CHAN_ID);

  always_comb begin
    if (strobes.submit)              opNext = MSG_RELEASE;
    else if (strobes.notifyNonempty) opNext = MSG_NONEMPTY;
    else                             opNext = MSG_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      memWrEn   <= 1'b0;
      memWrAddr <= '0;
      memWrData <= '0;
      msgValid  <= 1'b0;
      msgOpcode <= MSG_NONE;
      msgBufIdx <= '0;
      msgCount  <= '0;
      irq       <= 1'b0;
    end else begin
      memWrEn   <= strobes.wrAccept;
      memWrAddr <= {curIdx, fillCnt[OFF_W-1:0]};
      memWrData <= inData;
      msgValid  <= anyMsg;
      msgOpcode <= opNext;
      msgBufIdx <= curIdx;
      msgCount  <= strobes.submit ? subCount : '0;
      irq       <= anyMsg | (irq & ~irqClear);
    end
  end

  // R3: a release always reports a count between one and a full buffer
  assert_release_count_R3: assert property (@(posedge clk) disable iff (rst)
    (msgValid && (msgOpcode == MSG_RELEASE)) |->
      ((msgCount != '0) && (msgCount <= CNT_W'(BUF_WORDS))));

  // R8: every message is accompanied by a raised request
  assert_irq_with_msg_R8: assert property (@(posedge clk) disable iff (rst)
    msgValid |-> irq);

  // R8: the request holds until the host clears it
  assert_irq_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (irq && !irqClear) |=> irq);

endmodule

// File: rtl/chan_submit_ctrl.sv
module chan_submit_ctrl
  import csc_pkg::*;
#(
  parameter int WORD_W      = 32,
  parameter int BUF_WORDS   = 16,
  parameter int BUF_COUNT   = 4,
  parameter int CHAN_ID     = 1,
  parameter int CHAN_W      = 8,
  parameter bit NONEMPTY_EN = 1'b1,
  localparam int IDX_W  = (BUF_COUNT > 1) ? $clog2(BUF_COUNT) : 1,
  localparam int OFF_W  = (BUF_WORDS > 1) ? $clog2(BUF_WORDS) : 1,
  localparam int CNT_W  = $clog2(BUF_WORDS + 1),
  localparam int ADDR_W = IDX_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] inData,
  input  logic              inValid,
  output logic              inReady,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [WORD_W-1:0] memWrData,
  input  logic              relStrobe,
  input  logic [IDX_W-1:0]  relIndex,
  input  logic              flushStrobe,
  input  logic              irqClear,
  output logic              msgValid,
  output logic [CHAN_W-1:0] msgChan,
  output logic [1:0]        msgOpcode,
  output logic [IDX_W-1:0]  msgBufIdx,
  output logic [CNT_W-1:0]  msgCount,
  output logic              irq
);

  ctrl_strobe_t     strobes;
  logic [IDX_W-1:0] curIdx;
  logic [CNT_W-1:0] fillCnt;
  logic [CNT_W-1:0] subCount;

  csc_ctrl #(
    .BUF_WORDS  (BUF_WORDS),
    .BUF_COUNT  (BUF_COUNT),
    .NONEMPTY_EN(NONEMPTY_EN)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .inValid    (inValid),
    .flushStrobe(flushStrobe),
    .relStrobe  (relStrobe),
    .relIndex   (relIndex),
    .inReady    (inReady),
    .strobes    (strobes),
    .curIdx     (curIdx),
    .fillCnt    (fillCnt),
    .subCount   (subCount)
  );

  csc_datapath #(
    .WORD_W   (WORD_W),
    .BUF_WORDS(BUF_WORDS),
    .BUF_COUNT(BUF_COUNT),
    .CHAN_ID  (CHAN_ID),
    .CHAN_W   (CHAN_W)
  ) u_datapath (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .curIdx   (curIdx),
    .fillCnt  (fillCnt),
    .subCount (subCount),
    .inData   (inData),
    .irqClear (irqClear),
    .memWrEn  (memWrEn),
    .memWrAddr(memWrAddr),
    .memWrData(memWrData),
    .msgValid (msgValid),
    .msgChan  (msgChan),
    .msgOpcode(msgOpcode),
    .msgBufIdx(msgBufIdx),
    .msgCount (msgCount),
    .irq      (irq)
  );

endmodule

// File: tb/chan_submit_ctrl_bench.sv
module chan_submit_ctrl_bench;

  localparam int WW = 16;
  localparam int BW = 4;
  localparam int BC = 4;
  localparam int CH = 3;
  localparam int CHW = 8;
  localparam int IW = 2;
  localparam int OW = 2;
  localparam int CW = 3;
  localparam int AW = IW + OW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [WW-1:0] inData = '0;
  logic inValid = 1'b0;
  logic relStrobe = 1'b0;
  logic [IW-1:0] relIndex = '0;
  logic flushStrobe = 1'b0;
  logic irqClear = 1'b0;

  logic inReady, memWrEn, msgValid, irq;
  logic [AW-1:0] memWrAddr;
  logic [WW-1:0] memWrData;
  logic [CHW-1:0] msgChan;
  logic [1:0] msgOpcode;
  logic [IW-1:0] msgBufIdx;
  logic [CW-1:0] msgCount;

  logic qReady, qWrEn, qMsgValid, qIrq;
  logic [AW-1:0] qWrAddr;
  logic [WW-1:0] qWrData;
  logic [CHW-1:0] qChan;
  logic [1:0] qOpcode;
  logic [IW-1:0] qBufIdx;
  logic [CW-1:0] qCount;

  always #2.5 clk = ~clk;

  chan_submit_ctrl #(.WORD_W(WW), .BUF_WORDS(BW), .BUF_COUNT(BC), .CHAN_ID(CH),
                     .CHAN_W(CHW), .NONEMPTY_EN(1'b1)) u_chan_submit_ctrl (
    .clk(clk), .rst(rst), .inData(inData), .inValid(inValid), .inReady(inReady),
    .memWrEn(memWrEn), .memWrAddr(memWrAddr), .memWrData(memWrData),
    .relStrobe(relStrobe), .relIndex(relIndex), .flushStrobe(flushStrobe),
    .irqClear(irqClear), .msgValid(msgValid), .msgChan(msgChan),
    .msgOpcode(msgOpcode), .msgBufIdx(msgBufIdx), .msgCount(msgCount), .irq(irq));

  chan_submit_ctrl #(.WORD_W(WW), .BUF_WORDS(BW), .BUF_COUNT(BC), .CHAN_ID(CH),
                     .CHAN_W(CHW), .NONEMPTY_EN(1'b0)) u_chan_submit_ctrl_quiet (
    .clk(clk), .rst(rst), .inData(inData), .inValid(inValid), .inReady(qReady),
    .memWrEn(qWrEn), .memWrAddr(qWrAddr), .memWrData(qWrData),
    .relStrobe(relStrobe), .relIndex(relIndex), .flushStrobe(flushStrobe),
    .irqClear(irqClear), .msgValid(qMsgValid), .msgChan(qChan),
    .msgOpcode(qOpcode), .msgBufIdx(qBufIdx), .msgCount(qCount), .irq(qIrq));

  int checks = 0;
  int errors = 0;
  int nRel = 0;
  int qRel = 0;
  bit done = 1'b0;

  logic [AW+WW-1:0] expWr[$];
  logic [2+IW+CW-1:0] expMsg[$];

  int mIdx = 0;
  int mFill = 0;
  bit mFree[BC];

  task automatic check(input bit ok, input string tag, input logic [31:0] got,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic submitModel(input int cnt);
    expMsg.push_back({2'd1, IW'(mIdx), CW'(cnt)});
    nRel++;
    mFree[mIdx] = 1'b0;
    mIdx = (mIdx + 1) % BC;
    mFill = 0;
  endtask

  // drive one word; model pushes the expected write and messages
  task automatic sendWord(input logic [WW-1:0] d, input bit flush, input bit clr);
    int cnt;
    bit sub;
    @(negedge clk);
    inValid = 1'b1; inData = d; flushStrobe = flush; irqClear = clr;
    relStrobe = 1'b0;
    check(inReady === mFree[mIdx], "R6 inReady", 32'(inReady), 32'(mFree[mIdx]));
    if (mFree[mIdx]) begin
      expWr.push_back({IW'(mIdx), OW'(mFill), d});   // R2
      cnt = mFill + 1;
      sub = (cnt == BW) || flush;
      if (mFill == 0 && !sub) expMsg.push_back({2'd2, IW'(mIdx), CW'(0)}); // R7
      if (sub) submitModel(cnt);                     // R3 R4 R5
      else mFill = cnt;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0; flushStrobe = 1'b0; relStrobe = 1'b0; irqClear = 1'b0;
    end
  endtask

  task automatic flushOnly();
    @(negedge clk);
    inValid = 1'b0; flushStrobe = 1'b1; relStrobe = 1'b0; irqClear = 1'b0;
    if (mFill != 0) submitModel(mFill);             // R5
  endtask

  task automatic releaseBuf(input int i);
    @(negedge clk);
    inValid = 1'b0; flushStrobe = 1'b0; relStrobe = 1'b1; irqClear = 1'b0;
    relIndex = IW'(i);
    mFree[i] = 1'b1;
  endtask

  task automatic clearIrq();
    @(negedge clk);
    inValid = 1'b0; flushStrobe = 1'b0; relStrobe = 1'b0; irqClear = 1'b1;
  endtask

  // monitor: pops the scoreboard as results appear
  always @(negedge clk) begin
    if (!rst) begin
      if (memWrEn) begin
        if (expWr.size() == 0)
          check(1'b0, "R2 unexpected write", 32'({memWrAddr, memWrData}), 32'(0));
        else begin
          logic [AW+WW-1:0] e;
          e = expWr.pop_front();
          check({memWrAddr, memWrData} === e, "R2 write", 32'({memWrAddr, memWrData}), 32'(e));
        end
      end
      if (msgValid) begin
        check(msgChan === CHW'(CH), "R9 channel", 32'(msgChan), 32'(CH));
        if (expMsg.size() == 0)
          check(1'b0, "R5 unexpected message", 32'({msgOpcode, msgBufIdx, msgCount}), 32'(0));
        else begin
          logic [2+IW+CW-1:0] e;
          e = expMsg.pop_front();
          check({msgOpcode, msgBufIdx, msgCount} === e,
                (e[2+IW+CW-1 -: 2] == 2'd1) ? "R3 release msg" : "R7 nonempty msg",
                32'({msgOpcode, msgBufIdx, msgCount}), 32'(e));
        end
      end
      if (qMsgValid) begin
        if (qOpcode == 2'd2) check(1'b0, "R7 disabled nonempty", 32'(qOpcode), 32'(1));
        else qRel++;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < BC; i++) mFree[i] = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check(inReady === 1'b1, "R1 inReady", 32'(inReady), 32'(1));
    check(msgValid === 1'b0, "R1 msgValid", 32'(msgValid), 32'(0));
    check(irq === 1'b0, "R1 irq", 32'(irq), 32'(0));
    check(memWrEn === 1'b0, "R1 memWrEn", 32'(memWrEn), 32'(0));

    // fill buffer 0 back to back: nonempty then full release (R2 R3 R7)
    for (int i = 0; i < BW; i++) sendWord(WW'(16'hA000 + i), 1'b0, 1'b0);
    idle(2);
    check(irq === 1'b1, "R8 irq after release", 32'(irq), 32'(1));
    clearIrq();
    idle(1);
    check(irq === 1'b0, "R8 irq cleared", 32'(irq), 32'(0));

    // partial buffer 1, flushed after a gap (R5 R4)
    sendWord(16'hB001, 1'b0, 1'b0);
    sendWord(16'hB002, 1'b0, 1'b0);
    idle(3);
    check(irq === 1'b1, "R8 irq after nonempty", 32'(irq), 32'(1));
    clearIrq();
    flushOnly();
    idle(2);
    check(irq === 1'b1, "R8 irq after flush release", 32'(irq), 32'(1));
    clearIrq();

    // flush on empty buffer 2 yields nothing (R5)
    flushOnly();
    idle(3);
    check(irq === 1'b0, "R5 empty flush no irq", 32'(irq), 32'(0));

    // flush coinciding with the filling word: one full release (R5)
    for (int i = 0; i < BW - 1; i++) sendWord(WW'(16'hC000 + i), 1'b0, 1'b0);
    sendWord(16'hC0FF, 1'b1, 1'b0);

    // first word with flush: release of one, no nonempty (R7 R5)
    sendWord(16'hD001, 1'b1, 1'b0);
    idle(2);

    // all buffers owned by host: input stalls (R6)
    check(inReady === 1'b0, "R6 stalled", 32'(inReady), 32'(0));
    @(negedge clk);
    inValid = 1'b1; inData = 16'hEEEE;
    idle(0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(inReady === 1'b0, "R6 held stall", 32'(inReady), 32'(0));
    end
    idle(1);
    releaseBuf(2);
    idle(1);
    check(inReady === 1'b0, "R6 other index freed", 32'(inReady), 32'(0));
    releaseBuf(0);
    idle(1);
    check(inReady === 1'b1, "R6 own index freed", 32'(inReady), 32'(1));

    // clear in the same cycle as a new release keeps irq (R8)
    sendWord(16'hF001, 1'b1, 1'b1);
    idle(1);
    check(irq === 1'b1, "R8 set wins over clear", 32'(irq), 32'(1));

    // wrap to buffer 1 after release: nonempty re-armed (R4 R7)
    releaseBuf(1);
    releaseBuf(3);
    for (int i = 0; i < BW; i++) sendWord(WW'(16'h5000 + i), 1'b0, 1'b0);
    idle(4);

    check(expWr.size() == 0, "R2 writes drained", 32'(expWr.size()), 32'(0));
    check(expMsg.size() == 0, "R3 messages drained", 32'(expMsg.size()), 32'(0));
    check(qRel == nRel, "R7 disabled copy releases", 32'(qRel), 32'(nRel));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule